// File: doc/BRIEF.md
# Bit-Serial Trinomial Galois-Field Multiplier

This block multiplies two elements of GF(2^M). Each element is an M-bit polynomial over GF(2), and the field is defined by the trinomial x^M + x^K + 1. A start strobe captures both operands. Over the next M clock cycles, one bit of the second operand per cycle, least significant first, is broadcast to a row of M one-bit cells. Each cell holds one coefficient of the first operand, which is multiplied by x every cycle, and one coefficient of the running product.

Reduction happens as the operand shifts. The coefficient that leaves the top cell is fed back into cell 0 and cell K, because x^M equals x^K + 1 in this field. Product bits stay in their own cells and never travel along the row. When the last iteration finishes, a one-cycle done pulse marks the product as valid. The product then stays on the output until the next accepted start.

Top module: `gfm_trinom_mul`

## Requirements
- R1: After reset, `done` is low and `prod` is all zeros.
- R2: A `start` pulse seen while the block is idle captures `opa` and `opb` in that cycle and clears the product. Later changes on `opa` and `opb` do not alter the result.
- R3: `done` goes high for exactly one cycle, M clock edges after the edge that accepted `start`.
- R4: When `done` is high, `prod` equals `opa` times `opb` reduced modulo x^M + x^K + 1. Bit i of each bus is the coefficient of x^i. For example, with M=7 and K=4, 0x40 times 0x02 gives 0x11.
- R5: A `start` pulse during the M busy cycles is ignored. The running product and the `done` timing stay those of the operation already in progress.
- R6: While idle with `start` low, `prod` stays unchanged.
- R7: Multiplying by 0x1 returns the first operand unchanged, and multiplying by zero returns zero.
- R8: A `start` pulse in the same cycle that `done` is high is accepted, so operations can run back to back every M+1 cycles.
- R9: The same behaviour holds for a wide field, with M=233 and K=74.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request, accepted only when idle |
| opa | input | M | First operand, the one that shifts along the cells |
| opb | input | M | Second operand, broadcast one bit per cycle |
| done | output | 1 | One-cycle pulse, product valid |
| prod | output | M | Reduced product, held until the next accepted start |

## Verification
The bound checker watches the control skeleton on every cycle. It checks that an accepted start clears the product and enters the busy state, and that done is a single-cycle pulse arriving exactly M busy cycles after acceptance. It also checks that a start during busy does not cut the run short, and that the product is frozen while idle. Whether the product bits are arithmetically correct, including the feedback into cells 0 and K, can only be shown by the bench. The bench compares every clock against a behavioural field model, using known products, identity and zero operands, overlapping requests, back-to-back operations and random operands at both field sizes.

// File: rtl/gfm_pkg.sv
`timescale 1ns/1ps
package gfm_pkg;
  // Incoming operand bit of a cell: neighbour bit, plus feedback on tap cells.
  function automatic logic cell_shift_in(input logic nbr, input logic fb, input bit tap);
    return nbr ^ (fb & logic'(tap));
  endfunction

  // One partial-product accumulation step of a cell.
  function automatic logic cell_accum(input logic acc, input logic a_bit, input logic b_bit);
    return acc ^ (a_bit & b_bit);
  endfunction

  // A cell takes the feedback when its position is 0 or K.
  function automatic bit is_tap(input int pos, input int k);
    return (pos == 0) || (pos == k);
  endfunction
endpackage

// File: rtl/gfm_cell.sv
`timescale 1ns/1ps
module gfm_cell #(
  parameter bit TAP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  logic a_init,
  input  logic a_nbr,
  input  logic fb,
  input  logic b_bit,
  output logic a_q,
  output logic c_q
);
  import gfm_pkg::*;

  logic a_next;
  assign a_next = cell_shift_in(a_nbr, fb, TAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      c_q <= 1'b0;
    end else if (load) begin
      a_q <= a_init;
      c_q <= 1'b0;
    end else if (step) begin
      c_q <= cell_accum(c_q, a_q, b_bit);
      a_q <= a_next;
    end
  end
endmodule

// File: rtl/gfm_seq.sv
`timescale 1ns/1ps
module gfm_seq #(
  parameter int M = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = (M > 1) ? $clog2(M) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(M - 1);

  logic [CW-1:0] iter_q;

  assign load = start & ~busy;
  assign step = busy;
  assign last = busy & (iter_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      iter_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        busy   <= 1'b1;
        iter_q <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      iter_q <= iter_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gfm_bcast.sv
`timescale 1ns/1ps
module gfm_bcast #(
  parameter int M = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [M-1:0] opb,
  output logic         b_bit
);
  logic [M-1:0] b_sh;

  assign b_bit = b_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     b_sh <= '0;
    else if (load)  b_sh <= opb;
    else if (step)  b_sh <= {1'b0, b_sh[M-1:1]};
  end
endmodule

// File: rtl/gfm_trinom_mul.sv
`timescale 1ns/1ps
module gfm_trinom_mul #(
  parameter int M = 7,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] opa,
  input  logic [M-1:0] opb,
  output logic         done,
  output logic [M-1:0] prod
);
  import gfm_pkg::*;

  // Named internal events, observed by the bound checker.
  logic         load_evt;
  logic         step_evt;
  logic         last_evt;
  logic         busy_w;
  logic         b_bit;
  logic         fb_bit;
  logic [M-1:0] a_vec;
  logic [M-1:0] nbr_vec;

  gfm_seq #(.M(M)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load_evt), .step(step_evt), .last(last_evt),
    .busy(busy_w), .done(done)
  );

  gfm_bcast #(.M(M)) u_bcast (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .step(step_evt),
    .opb(opb), .b_bit(b_bit)
  );

  assign fb_bit = a_vec[M-1];

  for (genvar j = 0; j < M; j++) begin : g_cell
    if (j == 0) begin : g_first
      assign nbr_vec[j] = 1'b0;
    end else begin : g_rest
      assign nbr_vec[j] = a_vec[j-1];
    end

    gfm_cell #(.TAP(is_tap(j, K))) u_cell (
      .clk(clk), .rst_n(rst_n), .load(load_evt), .step(step_evt),
      .a_init(opa[j]), .a_nbr(nbr_vec[j]), .fb(fb_bit), .b_bit(b_bit),
      .a_q(a_vec[j]), .c_q(prod[j])
    );
  end
endmodule

// File: rtl/gfm_trinom_mul_chk.sv
`timescale 1ns/1ps
module gfm_trinom_mul_chk #(
  parameter int M = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [M-1:0] prod,
  input logic         busy_w,
  input logic         load_evt,
  input logic         last_evt
);
  localparam int RW = $clog2(M + 1) + 1;

  // Busy cycles since the last accepted start.
  logic [RW-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (load_evt) run_len <= '0;
    else if (busy_w)   run_len <= run_len + 1'b1;
  end

  assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (busy_w && prod == '0));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> done);

  assert_done_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == RW'(M)));

  assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && start && !last_evt) |=> busy_w);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !start) |=> $stable(prod));
endmodule

bind gfm_trinom_mul gfm_trinom_mul_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .prod(prod),
  .busy_w(busy_w), .load_evt(load_evt), .last_evt(last_evt)
);

// File: tb/gfm_trinom_mul_test.sv
`timescale 1ns/1ps
package gfm_tb_pkg;
  // Full carry-less product, then fold the high terms down from the top.
  function automatic logic [255:0] gf_ref(input logic [255:0] a, input logic [255:0] b,
                                          input int m, input int k);
    logic [511:0] p;
    p = '0;
    for (int i = 0; i < m; i++)
      if (b[i]) p = p ^ ({256'b0, a} << i);
    for (int d = 2 * m - 2; d >= m; d--) begin
      if (p[d]) begin
        p[d]         = 1'b0;
        p[d - m]     = ~p[d - m];
        p[d - m + k] = ~p[d - m + k];
      end
    end
    return p[255:0];
  endfunction
endpackage

module gfm_ref_model #(
  parameter int M = 7,
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] opa,
  input  logic [M-1:0] opb,
  output logic         exp_done,
  output logic         exp_valid,
  output logic [M-1:0] exp_prod
);
  int left;
  logic [255:0] ta, tb, r;
  logic [M-1:0] pending;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left = 0;
      pending = '0;
      exp_done  <= 1'b0;
      exp_valid <= 1'b1;
      exp_prod  <= '0;
    end else begin
      exp_done <= 1'b0;
      if (left > 0) begin
        left = left - 1;
        if (left == 0) begin
          exp_done  <= 1'b1;
          exp_valid <= 1'b1;
          exp_prod  <= pending;
        end
      end else if (start) begin
        ta = '0; tb = '0;
        ta[M-1:0] = opa;
        tb[M-1:0] = opb;
        r = gfm_tb_pkg::gf_ref(ta, tb, M, K);
        pending = r[M-1:0];
        left = M;
        exp_valid <= 1'b0;
      end
    end
  end
endmodule

module gfm_trinom_mul_test;
  import gfm_tb_pkg::*;

  localparam int MS = 7;
  localparam int KS = 4;
  localparam int MB = 233;
  localparam int KB = 74;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start_s = 1'b0, start_b = 1'b0;
  logic [MS-1:0] opa_s = '0, opb_s = '0, prod_s, exp_prod_s;
  logic [MB-1:0] opa_b = '0, opb_b = '0, prod_b, exp_prod_b;
  logic          done_s, done_b, exp_done_s, exp_done_b, exp_valid_s, exp_valid_b;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  gfm_trinom_mul #(.M(MS), .K(KS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start_s), .opa(opa_s), .opb(opb_s),
    .done(done_s), .prod(prod_s)
  );
  gfm_trinom_mul #(.M(MB), .K(KB)) uut_big (
    .clk(clk), .rst_n(rst_n), .start(start_b), .opa(opa_b), .opb(opb_b),
    .done(done_b), .prod(prod_b)
  );

  gfm_ref_model #(.M(MS), .K(KS)) model_s (
    .clk(clk), .rst_n(rst_n), .start(start_s), .opa(opa_s), .opb(opb_s),
    .exp_done(exp_done_s), .exp_valid(exp_valid_s), .exp_prod(exp_prod_s)
  );
  gfm_ref_model #(.M(MB), .K(KB)) model_b (
    .clk(clk), .rst_n(rst_n), .start(start_b), .opa(opa_b), .opb(opb_b),
    .exp_done(exp_done_b), .exp_valid(exp_valid_b), .exp_prod(exp_prod_b)
  );

  task automatic check(input bit ok, input string tag, input logic [255:0] got,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Per-clock comparison against the behavioural models.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(done_s == exp_done_s, "R3 small done", 256'(done_s), 256'(exp_done_s));
      if (exp_valid_s) check(prod_s == exp_prod_s, "R6 small prod", 256'(prod_s), 256'(exp_prod_s));
      check(done_b == exp_done_b, "R9 big done", 256'(done_b), 256'(exp_done_b));
      if (exp_valid_b) check(prod_b == exp_prod_b, "R9 big prod", 256'(prod_b), 256'(exp_prod_b));
    end
  end

  function automatic logic [MS-1:0] ref_s(input logic [MS-1:0] a, input logic [MS-1:0] b);
    logic [255:0] r;
    r = gf_ref(256'(a), 256'(b), MS, KS);
    return r[MS-1:0];
  endfunction

  function automatic logic [MB-1:0] ref_b(input logic [MB-1:0] a, input logic [MB-1:0] b);
    logic [255:0] r;
    r = gf_ref(256'(a), 256'(b), MB, KB);
    return r[MB-1:0];
  endfunction

  function automatic logic [MB-1:0] rand_b();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
    return v[MB-1:0];
  endfunction

  task automatic go_s(input logic [MS-1:0] a, input logic [MS-1:0] b);
    opa_s = a; opb_s = b; start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
  endtask

  task automatic wait_s(output int n);
    n = 0;
    while (!done_s && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic go_b(input logic [MB-1:0] a, input logic [MB-1:0] b);
    opa_b = a; opb_b = b; start_b = 1'b1;
    @(negedge clk);
    start_b = 1'b0;
  endtask

  task automatic wait_b(output int n);
    n = 0;
    while (!done_b && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int n;
    logic [MS-1:0] a, b, held;
    logic [MB-1:0] ab, bb, eb;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(done_s == 1'b0, "R1 done", 256'(done_s), 256'(0));
    check(prod_s == '0, "R1 prod", 256'(prod_s), 256'(0));
    check(prod_b == '0, "R1 big prod", 256'(prod_b), 256'(0));

    // R3 / R4: x^6 * x = x^4 + 1
    go_s(7'h40, 7'h02);
    wait_s(n);
    check(n == MS, "R3 latency", 256'(n), 256'(MS));
    check(prod_s == 7'h11, "R4 known product", 256'(prod_s), 256'(7'h11));

    // R8: start in the done cycle
    go_s(7'h7f, 7'h7f);
    wait_s(n);
    check(n == MS, "R8 back-to-back latency", 256'(n), 256'(MS));
    check(prod_s == ref_s(7'h7f, 7'h7f), "R4 all ones", 256'(prod_s), 256'(ref_s(7'h7f, 7'h7f)));

    // R7: identity and zero
    go_s(7'h5a, 7'h01);
    wait_s(n);
    check(prod_s == 7'h5a, "R7 times one", 256'(prod_s), 256'(7'h5a));
    go_s(7'h5a, 7'h00);
    wait_s(n);
    check(prod_s == 7'h00, "R7 times zero", 256'(prod_s), 256'(0));

    // R2: operands changed after capture
    go_s(7'h33, 7'h65);
    opa_s = 7'h7f; opb_s = 7'h0f;
    wait_s(n);
    check(prod_s == ref_s(7'h33, 7'h65), "R2 capture", 256'(prod_s), 256'(ref_s(7'h33, 7'h65)));

    // R5: start while busy
    go_s(7'h21, 7'h4c);
    @(negedge clk);
    opa_s = 7'h7f; opb_s = 7'h7f; start_s = 1'b1;
    @(negedge clk);
    start_s = 1'b0;
    wait_s(n);
    n = n + 2;
    check(n == MS, "R5 latency unchanged", 256'(n), 256'(MS));
    check(prod_s == ref_s(7'h21, 7'h4c), "R5 result kept", 256'(prod_s), 256'(ref_s(7'h21, 7'h4c)));

    // R6: hold while idle
    held = prod_s;
    for (int i = 0; i < 5; i++) begin
      opa_s = 7'(i * 19 + 3); opb_s = 7'(i * 37 + 5);
      @(negedge clk);
    end
    check(prod_s == held, "R6 hold", 256'(prod_s), 256'(held));

    // R4: random small operands
    for (int i = 0; i < 20; i++) begin
      a = 7'($urandom); b = 7'($urandom);
      go_s(a, b);
      wait_s(n);
      check(prod_s == ref_s(a, b), "R4 random", 256'(prod_s), 256'(ref_s(a, b)));
    end

    // R9: wide field, x^232 * x = x^74 + 1
    ab = '0; ab[MB-1] = 1'b1;
    bb = '0; bb[1] = 1'b1;
    eb = '0; eb[0] = 1'b1; eb[KB] = 1'b1;
    go_b(ab, bb);
    wait_b(n);
    check(n == MB, "R9 latency", 256'(n), 256'(MB));
    check(prod_b == eb, "R9 wrap product", 256'(prod_b), 256'(eb));
    for (int i = 0; i < 4; i++) begin
      ab = rand_b(); bb = rand_b();
      go_b(ab, bb);
      wait_b(n);
      check(prod_b == ref_b(ab, bb), "R9 random", 256'(prod_b), 256'(ref_b(ab, bb)));
    end

    repeat (3) @(negedge clk);
    summary();
  end
endmodule